// File: doc/BRIEF.md
# Register/Memory Operand Decoder

This block takes in, one byte at a time, a 16-bit real-mode two-operand instruction from the move or add register/memory families. It collects the opcode, the operand-specifier byte and up to two displacement bytes. It then reports where each operand lives: a register number, or an effective memory address built from the base and index registers and the displacement. It also reports the operand width and the instruction length in bytes. The current values of the eight 16-bit general registers come in on one input port. The block uses them at the moment the last byte is accepted.

Bytes arrive through a valid/ready handshake. After the last byte of an instruction, the block raises `done_o` for exactly one cycle. During that cycle it holds `byte_ready_o` low, and after it the block takes the next opcode. An opcode outside the two families raises `illegal_o` for one cycle instead.

Top module: `modrm_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, byte_ready_o is 1, done_o and illegal_o are 0, and every result output is 0.
- R2: An opcode byte of the form 100010dw (move) or 000000dw (add) is accepted. Any other opcode byte is consumed and gives a single-cycle illegal_o pulse in the cycle after it is accepted, with done_o low and byte_ready_o low. All result outputs keep their previous values.
- R3: Opcode bit 1 (d) orders the operands. With d=0, the register field (second byte bits 5:3) is the source and the r/m side is the destination. With d=1, the register field is the destination and the r/m side is the source. At most one operand is in memory, and a memory operand reports register number 0.
- R4: Opcode bit 0 (w) drives word_o: 1 means word-sized, 0 means byte-sized. Register numbers are passed through unchanged (0 = AL/AX, 3 = BL/BX, and so on).
- R5: With mod (second byte bits 7:6) = 11, both operands are registers and the r/m field (bits 2:0) gives the second register number. No displacement follows, len_o is 2 and ea_o is 0.
- R6: With mod = 00 and r/m other than 110, the memory address is the base/index sum with no displacement, and len_o is 2. r/m codes 0..7 select BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX.
- R7: With mod = 01, one displacement byte follows. It is sign-extended and added to the base/index sum, and len_o is 3.
- R8: With mod = 10, two displacement bytes follow, low byte first. They are added to the base/index sum, and len_o is 4.
- R9: With mod = 00 and r/m = 110, the two following bytes (low byte first) are the address itself, with no register added, and len_o is 4.
- R10: Every address sum wraps modulo 2^16.
- R11: done_o is high for exactly one cycle, the cycle after the final byte is accepted, and byte_ready_o is low during that cycle. Register values are taken from regs_i in the cycle the final byte is accepted, so later changes to regs_i do not alter ea_o.
- R12: A byte is consumed only when byte_valid_i and byte_ready_o are both high. Idle cycles between bytes neither advance decoding nor raise done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_valid_i | input | 1 | Instruction byte offered |
| byte_i | input | 8 | Instruction byte |
| byte_ready_o | output | 1 | Block can take a byte |
| regs_i | input | 128 | Register n (0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI, 7 DI) at bits 16n+15:16n |
| done_o | output | 1 | One-cycle pulse: results valid |
| illegal_o | output | 1 | One-cycle pulse: unrecognised opcode |
| word_o | output | 1 | 1 = word operands, 0 = byte operands |
| src_mem_o | output | 1 | Source operand is in memory |
| src_reg_o | output | 3 | Source register number |
| dst_mem_o | output | 1 | Destination operand is in memory |
| dst_reg_o | output | 3 | Destination register number |
| ea_o | output | 16 | Effective address of the memory operand |
| len_o | output | 3 | Instruction length in bytes |

## Verification
Every result, and the done or illegal pulse, is due in the first cycle after the clock edge that accepts the final byte (or the bad opcode). The bench drives bytes at the falling edge and samples all outputs at the next falling edge, so it reads exactly that cycle. One falling edge later it confirms that the pulse has dropped and that byte_ready_o is high again. Stalls are inserted between bytes, and regs_i is changed right after the final edge, to show that neither shifts the due cycle or the captured address.

// File: rtl/modrm_pkg.sv
package modrm_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 16;
  localparam int NUM_REGS = 8;
  localparam int REG_SEL_W = $clog2(NUM_REGS);

  localparam logic [1:0] MOD_MEM0 = 2'b00;
  localparam logic [1:0] MOD_MEM8 = 2'b01;
  localparam logic [1:0] MOD_MEM16 = 2'b10;
  localparam logic [1:0] MOD_REG  = 2'b11;
  localparam logic [2:0] RM_DIRECT = 3'b110;

  typedef enum logic [2:0] {
    ST_OPC, ST_MODRM, ST_DLO, ST_DHI, ST_DONE, ST_ILL
  } seq_state_e;

  function automatic logic [1:0] disp_bytes(input logic [1:0] md, input logic [2:0] rm);
    case (md)
      MOD_MEM8:  disp_bytes = 2'd1;
      MOD_MEM16: disp_bytes = 2'd2;
      MOD_MEM0:  disp_bytes = (rm == RM_DIRECT) ? 2'd2 : 2'd0;
      default:   disp_bytes = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/modrm_opcode_dec.sv
module modrm_opcode_dec
  import modrm_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode_i,
  output logic              legal_o
);
  localparam logic [5:0] FAM_MOV = 6'b100010;
  localparam logic [5:0] FAM_ADD = 6'b000000;

  always_comb begin
    legal_o = (opcode_i[7:2] == FAM_MOV) || (opcode_i[7:2] == FAM_ADD);
  end
endmodule

// File: rtl/modrm_byte_seq.sv
module modrm_byte_seq
  import modrm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              legal_i,
  output logic              ready_o,
  output logic              fin_o,
  output logic [BYTE_W-1:0] opcode_o,
  output logic [BYTE_W-1:0] modrm_o,
  output logic [BYTE_W-1:0] disp_lo_o,
  output logic [1:0]        ndisp_o,
  output logic              done_o,
  output logic              illegal_o
);
  seq_state_e state_q;
  logic [BYTE_W-1:0] opcode_q, modrm_q, dlo_q;
  logic acc;

  assign ready_o = (state_q != ST_DONE) && (state_q != ST_ILL);
  assign acc     = valid_i && ready_o;
  // second byte is live on the bus while it is being accepted
  assign modrm_o = (state_q == ST_MODRM) ? byte_i : modrm_q;
  assign ndisp_o = disp_bytes(modrm_o[7:6], modrm_o[2:0]);
  assign opcode_o  = opcode_q;
  assign disp_lo_o = dlo_q;
  assign done_o    = (state_q == ST_DONE);
  assign illegal_o = (state_q == ST_ILL);

  always_comb begin
    fin_o = 1'b0;
    if (acc) begin
      case (state_q)
        ST_MODRM: fin_o = (ndisp_o == 2'd0);
        ST_DLO:   fin_o = (ndisp_o == 2'd1);
        ST_DHI:   fin_o = 1'b1;
        default:  fin_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_OPC;
      opcode_q <= '0;
      modrm_q  <= '0;
      dlo_q    <= '0;
    end else begin
      case (state_q)
        ST_OPC: if (acc) begin
          opcode_q <= byte_i;
          state_q  <= legal_i ? ST_MODRM : ST_ILL;
        end
        ST_MODRM: if (acc) begin
          modrm_q <= byte_i;
          state_q <= (ndisp_o == 2'd0) ? ST_DONE : ST_DLO;
        end
        ST_DLO: if (acc) begin
          dlo_q   <= byte_i;
          state_q <= (ndisp_o == 2'd1) ? ST_DONE : ST_DHI;
        end
        ST_DHI: if (acc) state_q <= ST_DONE;
        default: state_q <= ST_OPC;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || illegal_o) |-> !ready_o); // R11
  AST_DONE_ILL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && illegal_o)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && ready_o) |=> $stable(state_q)); // R12
endmodule

// File: rtl/modrm_ea_calc.sv
module modrm_ea_calc
  import modrm_pkg::*;
#(
  parameter int AW = WORD_W
) (
  input  logic [1:0]             mod_i,
  input  logic [2:0]             rm_i,
  input  logic [NUM_REGS*AW-1:0] regs_i,
  input  logic [BYTE_W-1:0]      disp_lo_i,
  input  logic [BYTE_W-1:0]      cur_i,
  output logic [AW-1:0]          ea_o
);
  localparam int R_BX = 3, R_BP = 5, R_SI = 6, R_DI = 7;

  logic [AW-1:0] bx, bp, si, di, base, disp;

  assign bx = regs_i[R_BX*AW +: AW];
  assign bp = regs_i[R_BP*AW +: AW];
  assign si = regs_i[R_SI*AW +: AW];
  assign di = regs_i[R_DI*AW +: AW];

  always_comb begin
    case (rm_i)
      3'd0: base = bx + si;
      3'd1: base = bx + di;
      3'd2: base = bp + si;
      3'd3: base = bp + di;
      3'd4: base = si;
      3'd5: base = di;
      3'd6: base = (mod_i == MOD_MEM0) ? '0 : bp;
      default: base = bx;
    endcase
    case (mod_i)
      MOD_MEM8:  disp = AW'({{(AW-BYTE_W){cur_i[BYTE_W-1]}}, cur_i});
      MOD_MEM16: disp = AW'({cur_i, disp_lo_i});
      MOD_MEM0:  disp = (rm_i == RM_DIRECT) ? AW'({cur_i, disp_lo_i}) : '0;
      default:   disp = '0;
    endcase
    ea_o = base + disp; // wraps at AW bits
  end
endmodule

// File: rtl/modrm_decoder.sv
module modrm_decoder
  import modrm_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       byte_valid_i,
  input  logic [BYTE_W-1:0]          byte_i,
  output logic                       byte_ready_o,
  input  logic [NUM_REGS*WORD_W-1:0] regs_i,
  output logic                       done_o,
  output logic                       illegal_o,
  output logic                       word_o,
  output logic                       src_mem_o,
  output logic [REG_SEL_W-1:0]       src_reg_o,
  output logic                       dst_mem_o,
  output logic [REG_SEL_W-1:0]       dst_reg_o,
  output logic [WORD_W-1:0]          ea_o,
  output logic [2:0]                 len_o
);
  logic legal, fin;
  logic [BYTE_W-1:0] opcode, modrm, disp_lo;
  logic [1:0] ndisp;
  logic [WORD_W-1:0] ea_calc;
  logic rm_mem, dir;
  logic [REG_SEL_W-1:0] reg_f, rm_f;

  modrm_opcode_dec u_opdec (
    .opcode_i (byte_i),
    .legal_o  (legal)
  );

  modrm_byte_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (byte_valid_i),
    .byte_i    (byte_i),
    .legal_i   (legal),
    .ready_o   (byte_ready_o),
    .fin_o     (fin),
    .opcode_o  (opcode),
    .modrm_o   (modrm),
    .disp_lo_o (disp_lo),
    .ndisp_o   (ndisp),
    .done_o    (done_o),
    .illegal_o (illegal_o)
  );

  modrm_ea_calc #(.AW(WORD_W)) u_ea (
    .mod_i     (modrm[7:6]),
    .rm_i      (modrm[2:0]),
    .regs_i    (regs_i),
    .disp_lo_i (disp_lo),
    .cur_i     (byte_i),
    .ea_o      (ea_calc)
  );

  assign rm_mem = (modrm[7:6] != MOD_REG);
  assign dir    = opcode[1];
  assign reg_f  = modrm[5:3];
  assign rm_f   = rm_mem ? '0 : modrm[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o    <= 1'b0;
      src_mem_o <= 1'b0;
      src_reg_o <= '0;
      dst_mem_o <= 1'b0;
      dst_reg_o <= '0;
      ea_o      <= '0;
      len_o     <= '0;
    end else if (fin) begin
      word_o    <= opcode[0];
      src_mem_o <= dir ? rm_mem : 1'b0;
      src_reg_o <= dir ? rm_f : reg_f;
      dst_mem_o <= dir ? 1'b0 : rm_mem;
      dst_reg_o <= dir ? reg_f : rm_f;
      ea_o      <= rm_mem ? ea_calc : '0;
      len_o     <= 3'd2 + {1'b0, ndisp};
    end
  end

  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (len_o >= 3'd2 && len_o <= 3'd4)); // R7
  AST_ONE_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(src_mem_o && dst_mem_o)); // R3
  AST_REG_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !src_mem_o && !dst_mem_o) |-> (ea_o == '0 && len_o == 3'd2)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(ea_o) && $stable(len_o))); // R2
endmodule

// File: tb/modrm_decoder_tb.sv
module modrm_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  localparam int WATCHDOG = 20000;

  // {b0,b1,b2,b3, len, src_mem, src_reg, dst_mem, dst_reg, word, ea}
  localparam logic [59:0] VEC [NV] = '{
    {8'h88,8'hC3,8'h00,8'h00, 3'd2, 1'b0,3'd0, 1'b0,3'd3, 1'b0, 16'h0000},
    {8'h01,8'h81,8'h34,8'h12, 3'd4, 1'b0,3'd0, 1'b1,3'd0, 1'b1, 16'h2634},
    {8'h8B,8'h46,8'hFE,8'h00, 3'd3, 1'b1,3'd0, 1'b0,3'd0, 1'b1, 16'h1FFE},
    {8'h02,8'h0E,8'h34,8'h12, 3'd4, 1'b1,3'd0, 1'b0,3'd1, 1'b0, 16'h1234},
    {8'h89,8'h18,8'h00,8'h00, 3'd2, 1'b0,3'd3, 1'b1,3'd0, 1'b1, 16'h1030},
    {8'h03,8'h5B,8'h10,8'h00, 3'd3, 1'b1,3'd0, 1'b0,3'd3, 1'b1, 16'h2410},
    {8'h8A,8'h7C,8'h80,8'h00, 3'd3, 1'b1,3'd0, 1'b0,3'd7, 1'b0, 16'hFFB0},
    {8'h00,8'hD7,8'h00,8'h00, 3'd2, 1'b0,3'd2, 1'b0,3'd7, 1'b0, 16'h0000},
    {8'h01,8'h05,8'h00,8'h00, 3'd2, 1'b0,3'd0, 1'b1,3'd0, 1'b1, 16'h0400},
    {8'h8B,8'h87,8'hFF,8'hFF, 3'd4, 1'b1,3'd0, 1'b0,3'd0, 1'b1, 16'h0FFF},
    {8'h88,8'h02,8'h00,8'h00, 3'd2, 1'b0,3'd0, 1'b1,3'd0, 1'b0, 16'h2030}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [7:0] bval = '0;
  logic [127:0] regs;
  logic ready, done, illegal, word, src_mem, dst_mem;
  logic [2:0] src_reg, dst_reg, len;
  logic [15:0] ea;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modrm_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(valid), .byte_i(bval),
    .byte_ready_o(ready), .regs_i(regs), .done_o(done), .illegal_o(illegal),
    .word_o(word), .src_mem_o(src_mem), .src_reg_o(src_reg),
    .dst_mem_o(dst_mem), .dst_reg_o(dst_reg), .ea_o(ea), .len_o(len)
  );

  function automatic logic [127:0] mkregs(input logic [15:0] bx, bp, si, di);
    mkregs = {di, si, bp, 16'h0005, bx, 16'h0003, 16'h0002, 16'h0001};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    while (!ready) @(negedge clk);
    valid = 1'b1;
    bval  = b;
    @(posedge clk);
  endtask

  function automatic string mode_tag(input logic [7:0] m);
    if (m[7:6] == 2'b11) return "R5";
    if (m[7:6] == 2'b01) return "R7";
    if (m[7:6] == 2'b10) return "R8";
    if (m[2:0] == 3'b110) return "R9";
    return "R6";
  endfunction

  task automatic check_result(input logic [59:0] v);
    string t;
    t = mode_tag(v[51:44]);
    chk({31'd0, done}, 32'd1, "R11 done");
    chk({31'd0, ready}, 32'd0, "R11 ready low");
    chk({31'd0, illegal}, 32'd0, "R2 illegal");
    chk({24'd0, src_mem, src_reg, dst_mem, dst_reg}, {24'd0, v[24:17]}, "R3 operands");
    chk({31'd0, word}, {31'd0, v[16]}, "R4 width");
    chk({29'd0, len}, {29'd0, v[27:25]}, {t, " len"});
    chk({16'd0, ea}, {16'd0, v[15:0]}, {t, " ea"});
    @(negedge clk);
    chk({30'd0, done, ready}, 32'd1, "R11 pulse end");
  endtask

  initial begin
    regs = mkregs(16'h1000, 16'h2000, 16'h0030, 16'h0400);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({30'd0, ready, done}, 32'd2, "R1 ready/done");
    chk({31'd0, illegal}, 32'd0, "R1 illegal");
    chk({12'd0, word, src_mem, src_reg, dst_mem, dst_reg, len, ea}, 32'd0, "R1 results");
    rst_n = 1'b1;
    @(negedge clk);
    chk({30'd0, ready, done}, 32'd2, "R1 after release");

    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(VEC[i][27:25]); k++) put(VEC[i][59-8*k -: 8]);
      @(negedge clk);
      valid = 1'b0;
      check_result(VEC[i]);
    end

    // R2 illegal opcode: results unchanged from last vector
    put(8'h8C);
    @(negedge clk);
    valid = 1'b0;
    chk({30'd0, illegal, done}, 32'd2, "R2 illegal pulse");
    chk({31'd0, ready}, 32'd0, "R2 ready low");
    chk({16'd0, ea}, 32'h2030, "R2 ea held");
    chk({29'd0, len}, 32'd2, "R2 len held");
    @(negedge clk);
    chk({31'd0, illegal}, 32'd0, "R2 pulse end");

    // R12 stalls between bytes
    put(8'h01);
    @(negedge clk); valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk({31'd0, done}, 32'd0, "R12 no done in stall");
    end
    put(8'h81);
    @(negedge clk); valid = 1'b0;
    repeat (2) @(negedge clk);
    chk({31'd0, done}, 32'd0, "R12 no done mid-disp");
    put(8'h34);
    put(8'h12);
    @(negedge clk); valid = 1'b0;
    check_result(VEC[1]);

    // R10 wraparound, R11 register sampling at final byte
    regs = mkregs(16'hFFF0, 16'h2000, 16'h0020, 16'h0400);
    put(8'h03);
    put(8'h00);
    @(negedge clk);
    valid = 1'b0;
    regs = mkregs(16'h0000, 16'h0000, 16'h0000, 16'h0000);
    chk({16'd0, ea}, 32'h0010, "R10 wrap");
    chk({16'd0, ea}, 32'h0010, "R11 regs sampled at final byte");
    chk({31'd0, done}, 32'd1, "R11 done");

    // R9 direct address ignores BP
    regs = mkregs(16'h1000, 16'h7777, 16'h0030, 16'h0400);
    put(8'h8B); put(8'h06); put(8'hCD); put(8'hAB);
    @(negedge clk); valid = 1'b0;
    chk({16'd0, ea}, 32'hABCD, "R9 direct");
    chk({29'd0, len}, 32'd4, "R9 len");

    finished = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule